// File: doc/BRIEF.md
# Synchronous Buck Half-Bridge Gate Sequencer

This block sits between the PWM comparator of a voltage-mode buck controller and the two gate drivers of its power stage. It turns the comparator's duty bit into separate high-side and low-side gate enables and never lets the two overlap. Each handover between them passes through a fixed dead-time gap. The block also qualifies the raw overcurrent comparator into a clean single-clock strobe that the fault sequencer acts on.

When the sequencer grants driver permission at the start of a soft-start, the block keeps both gates off and reports tri-state. It stays there until two complete PWM pulses have been seen, so a converter starting into a precharged output does not pull that output down. The low side is always the first gate turned on, which charges the bootstrap capacitor. If the duty stays at 100% for a programmable number of whole oscillator cycles, the block inserts a forced low-side pulse of about half a cycle to top up the bootstrap supply.

The overcurrent sample is taken only while the high side conducts. It is ignored for a leading-edge blanking window after the high side turns on. It must then hold for a filter window of the same length before a strobe is issued, and at most one strobe is issued per switching cycle.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, and whenever driver permission is newly granted, `tristate` is 1 and both gate enables are 0 until two complete PWM pulses (a rise followed by a fall, counted only while permission is held) have been seen.
- R2: When `tristate` clears, the first gate enable driven high is `ls_gate`.
- R3: `hs_gate` and `ls_gate` are never 1 in the same clock cycle.
- R4: Between one gate enable falling and the other rising, both are 0 for at least `DEAD_CLKS` clock cycles.
- R5: Once armed, `hs_gate` follows a high `pwm_in` and `ls_gate` follows a low `pwm_in`, after the dead time. A PWM input held low for whole cycles (0% duty) keeps `ls_gate` continuously high.
- R6: A cycle tick (`cyc_tick`) that closes the `REFRESH_CYC`-th consecutive cycle with `pwm_in` high throughout forces `ls_gate` on for about half of the measured cycle length. The count then restarts, so the next forced pulse comes `REFRESH_CYC` full cycles later.
- R7: `oc_raw` is ignored during the first `BLANK_CLKS` clocks of each high-side on-time.
- R8: After blanking, `oc_raw` must be 1 for `BLANK_CLKS` consecutive clocks while `hs_gate` is high before `oc_strobe` pulses. The strobe is exactly one clock long.
- R9: `oc_strobe` pulses at most once between consecutive cycle ticks, even with `oc_raw` held high at 100% duty.
- R10: No `oc_strobe` is produced while `tristate` is 1.
- R11: Dropping `drv_permit` sets `tristate` and clears both gates on the next clock, and the two-pulse qualification of R1 starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM comparator output, 1 = high side requested |
| cyc_tick | input | 1 | One-clock pulse at the start of each oscillator cycle |
| drv_permit | input | 1 | Driver permission from the soft-start and fault sequencer |
| oc_raw | input | 1 | Unfiltered overcurrent comparator bit |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| tristate | output | 1 | 1 while both drivers are held in the off state awaiting qualification |
| oc_strobe | output | 1 | One-clock qualified overcurrent strobe |

## Verification
The bench places overcurrent pulses exactly at the edges of the blanking and filter windows. One sample too few must give no strobe, and exactly enough must give one; a window off by a clock either misses a real fault or trips on switching noise. It holds full duty for one cycle short of the refresh count and then exactly at it, and then checks that the next forced pulse comes a full count later. An off-by-one counter, or one that is not cleared after a refresh, moves the pulse by a cycle. It checks that a single pulse after a fresh permission is not enough to leave tri-state, and that the low side comes on first. A design that armed early or led with the high side would discharge a precharged output.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_HIGH = 2'd1,
        GS_LOW  = 2'd2
    } gate_sel_e;

    function automatic gate_sel_e sel_for_pwm(input logic pwm);
        return pwm ? GS_HIGH : GS_LOW;
    endfunction

endpackage

// File: rtl/hb_pulse_qual.sv
module hb_pulse_qual #(
    parameter int QUAL_PULSES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic permit,
    input  logic pwm,
    output logic armed
);
    localparam int CW = $clog2(QUAL_PULSES + 1);

    logic          pwm_q;
    logic          saw_rise;
    logic [CW-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q     <= 1'b0;
            saw_rise  <= 1'b0;
            pulse_cnt <= '0;
        end else begin
            pwm_q <= pwm;
            if (!permit) begin
                saw_rise  <= 1'b0;
                pulse_cnt <= '0;
            end else if (pwm && !pwm_q) begin
                saw_rise <= 1'b1;
            end else if (!pwm && pwm_q && saw_rise) begin
                saw_rise <= 1'b0;
                if (pulse_cnt != CW'(QUAL_PULSES))
                    pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    assign armed = (pulse_cnt == CW'(QUAL_PULSES));

    // R1
    arm_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> ($past(permit) && !$past(pwm)));

endmodule

// File: rtl/hb_boot_refresh.sv
module hb_boot_refresh #(
    parameter int REFRESH_CYC = 64,
    parameter int PER_W       = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic pwm,
    input  logic cyc_tick,
    output logic force_ls
);
    localparam int HW = $clog2(REFRESH_CYC + 1);

    logic [PER_W-1:0] per_cnt;
    logic [PER_W-1:0] frc_cnt;
    logic [HW-1:0]    hi_cnt;
    logic             low_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_cnt  <= '0;
            frc_cnt  <= '0;
            hi_cnt   <= '0;
            low_seen <= 1'b1;
        end else begin
            per_cnt <= cyc_tick ? '0 : per_cnt + 1'b1;
            if (frc_cnt != '0)
                frc_cnt <= frc_cnt - 1'b1;
            if (!active) begin
                hi_cnt   <= '0;
                low_seen <= 1'b1;
                frc_cnt  <= '0;
            end else if (cyc_tick) begin
                low_seen <= !pwm;
                if (!low_seen) begin
                    if (hi_cnt == HW'(REFRESH_CYC - 1)) begin
                        hi_cnt  <= '0;
                        frc_cnt <= (per_cnt + 1'b1) >> 1;
                    end else begin
                        hi_cnt <= hi_cnt + 1'b1;
                    end
                end else begin
                    hi_cnt <= '0;
                end
            end else if (!pwm) begin
                low_seen <= 1'b1;
            end
        end
    end

    assign force_ls = (frc_cnt != '0);

    // R6
    refresh_at_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(force_ls) |-> ($past(cyc_tick) && $past(active)));

    // R6
    refresh_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(force_ls) |-> $past(pwm));

endmodule

// File: rtl/hb_nonoverlap.sv
module hb_nonoverlap
    import hb_pkg::*;
#(
    parameter int DEAD_CLKS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  gate_sel_e req,
    output logic      hs,
    output logic      ls
);
    localparam int GW = $clog2(DEAD_CLKS + 1) > 0 ? $clog2(DEAD_CLKS + 1) : 1;

    gate_sel_e     cur;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= GS_OFF;
            gap_cnt <= '0;
        end else if (cur != GS_OFF && cur != req) begin
            cur     <= GS_OFF;
            gap_cnt <= GW'(DEAD_CLKS);
        end else if (cur == GS_OFF) begin
            if (gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
            else if (req != GS_OFF)
                cur <= req;
        end
    end

    assign hs = (cur == GS_HIGH);
    assign ls = (cur == GS_LOW);

    generate
        if (DEAD_CLKS > 0) begin : g_gap_chk
            // R4
            hs_to_ls_gap_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(hs) |=> !ls);
            // R4
            ls_to_hs_gap_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(ls) |=> !hs);
        end
    endgenerate

    // R3
    ls_rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ls) |-> !$past(hs));

endmodule

// File: rtl/hb_oc_qual.sv
module hb_oc_qual #(
    parameter int BLANK_CLKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_on,
    input  logic cyc_tick,
    input  logic oc_raw,
    output logic strobe
);
    localparam int BW = $clog2(BLANK_CLKS + 1);

    logic [BW-1:0] since_on;
    logic [BW-1:0] filt_cnt;
    logic          fired;
    logic          sample_ok;
    logic          hit;

    assign sample_ok = hs_on && (since_on == BW'(BLANK_CLKS)) && oc_raw;
    assign hit       = sample_ok && (filt_cnt == BW'(BLANK_CLKS - 1)) && !fired;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_on <= '0;
            filt_cnt <= '0;
            fired    <= 1'b0;
            strobe   <= 1'b0;
        end else begin
            if (!hs_on)
                since_on <= '0;
            else if (since_on != BW'(BLANK_CLKS))
                since_on <= since_on + 1'b1;

            if (!sample_ok)
                filt_cnt <= '0;
            else if (filt_cnt != BW'(BLANK_CLKS - 1))
                filt_cnt <= filt_cnt + 1'b1;

            strobe <= hit;
            if (hit)
                fired <= 1'b1;
            else if (cyc_tick)
                fired <= 1'b0;
        end
    end

    // R8
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R10
    strobe_needs_hs_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(hs_on));

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CLKS   = 2,
    parameter int BLANK_CLKS  = 6,
    parameter int REFRESH_CYC = 64,
    parameter int QUAL_PULSES = 2,
    parameter int PER_W       = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_in,
    input  logic cyc_tick,
    input  logic drv_permit,
    input  logic oc_raw,
    output logic hs_gate,
    output logic ls_gate,
    output logic tristate,
    output logic oc_strobe
);
    logic      armed;
    logic      active;
    logic      force_ls;
    logic      ls_first;
    logic      tri_q;
    gate_sel_e req;

    assign active = drv_permit && armed;

    hb_pulse_qual #(
        .QUAL_PULSES(QUAL_PULSES)
    ) u_qual (
        .clk    (clk),
        .rst    (rst),
        .permit (drv_permit),
        .pwm    (pwm_in),
        .armed  (armed)
    );

    hb_boot_refresh #(
        .REFRESH_CYC(REFRESH_CYC),
        .PER_W      (PER_W)
    ) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .pwm      (pwm_in),
        .cyc_tick (cyc_tick),
        .force_ls (force_ls)
    );

    always_comb begin
        if (!active)
            req = GS_OFF;
        else if (force_ls || !ls_first)
            req = GS_LOW;
        else
            req = sel_for_pwm(pwm_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ls_first <= 1'b0;
            tri_q    <= 1'b1;
        end else begin
            tri_q <= !active;
            if (!active)
                ls_first <= 1'b0;
            else if (ls_gate)
                ls_first <= 1'b1;
        end
    end

    hb_nonoverlap #(
        .DEAD_CLKS(DEAD_CLKS)
    ) u_gap (
        .clk (clk),
        .rst (rst),
        .req (req),
        .hs  (hs_gate),
        .ls  (ls_gate)
    );

    hb_oc_qual #(
        .BLANK_CLKS(BLANK_CLKS)
    ) u_oc (
        .clk      (clk),
        .rst      (rst),
        .hs_on    (hs_gate),
        .cyc_tick (cyc_tick),
        .oc_raw   (oc_raw),
        .strobe   (oc_strobe)
    );

    assign tristate = tri_q;

    // R11
    permit_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_permit |=> (tristate && !hs_gate && !ls_gate));

    // R1
    tri_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
        tristate |-> (!hs_gate && !ls_gate));

    // R2
    low_side_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate) |-> ls_first);

endmodule

// File: tb/hb_gate_ctrl_tb.sv
module hb_gate_ctrl_tb;
    localparam int P     = 40;
    localparam int DEAD  = 2;
    localparam int BLANK = 6;
    localparam int REFC  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwm_in = 1'b0, cyc_tick = 1'b0, drv_permit = 1'b0, oc_raw = 1'b0;
    logic hs, ls, tristate, oc_strobe;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_gate_ctrl #(
        .DEAD_CLKS(DEAD), .BLANK_CLKS(BLANK), .REFRESH_CYC(REFC),
        .QUAL_PULSES(2), .PER_W(16)
    ) u_dut (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .cyc_tick(cyc_tick),
        .drv_permit(drv_permit), .oc_raw(oc_raw),
        .hs_gate(hs), .ls_gate(ls), .tristate(tristate), .oc_strobe(oc_strobe)
    );

    // output monitor, sampled on the falling edge
    int overlap_n = 0, min_gap = 1000, off_run = 0, last_gate = 0;
    int ls_rise_n = 0, ls_run = 0, last_ls_len = 0;
    int strobe_n = 0, strobe_run = 0, max_strobe_run = 0, first_gate = 0;
    logic ls_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (hs && ls) overlap_n++;
            if (tristate) begin
                first_gate = 0;
                last_gate  = 0;
                off_run    = 0;
            end else begin
                if (first_gate == 0) first_gate = ls ? 2 : (hs ? 1 : 0);
                if (!hs && !ls) off_run++;
                else begin
                    if ((hs && last_gate == 2) || (ls && last_gate == 1))
                        if (off_run < min_gap) min_gap = off_run;
                    off_run   = 0;
                    last_gate = hs ? 1 : 2;
                end
            end
            if (ls && !ls_prev) ls_rise_n++;
            if (ls) ls_run++;
            else if (ls_prev) begin last_ls_len = ls_run; ls_run = 0; end
            ls_prev = ls;
            if (oc_strobe) begin
                strobe_n++;
                strobe_run++;
                if (strobe_run > max_strobe_run) max_strobe_run = strobe_run;
            end else strobe_run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycle(input int duty, input int probe,
                         output logic hs_s, output logic ls_s, output logic tri_s);
        hs_s = 1'b0; ls_s = 1'b0; tri_s = 1'b0;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            if (c == probe) begin hs_s = hs; ls_s = ls; tri_s = tristate; end
            cyc_tick = (c == 0);
            pwm_in   = (c < duty);
        end
    endtask

    task automatic run(input int duty, input int n);
        logic a, b, t;
        for (int i = 0; i < n; i++) cycle(duty, -1, a, b, t);
    endtask

    task automatic oc_cycle(input int duty, input int lo, input int hi);
        int hs_seen = 0;
        for (int c = 0; c < P; c++) begin
            @(negedge clk);
            if (hs) hs_seen++;
            oc_raw   = (hs_seen >= lo && hs_seen <= hi);
            cyc_tick = (c == 0);
            pwm_in   = (c < duty);
        end
        oc_raw = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(tristate == 1'b1, "R1 reset tristate", tristate, 1);
        check(!hs && !ls, "R1 reset gates off", {hs, ls}, 0);
        check(oc_strobe == 1'b0, "R10 reset strobe", oc_strobe, 0);
    endtask

    task automatic t_prebias;
        logic h, l, t;
        drv_permit = 1'b1;
        cycle(20, 30, h, l, t);
        check(t == 1'b1, "R1 tristate after one pulse", t, 1);
        check(!h && !l, "R1 gates off after one pulse", {h, l}, 0);
        cycle(20, 15, h, l, t);
        check(t == 1'b1, "R1 tristate before second fall", t, 1);
        cycle(20, 5, h, l, t);
        check(t == 1'b0, "R1 armed after two pulses", t, 0);
        check(first_gate == 2, "R2 low side first", first_gate, 2);
    endtask

    task automatic t_follow;
        logic h, l, t;
        cycle(20, 12, h, l, t);
        check(h && !l, "R5 high side during pwm high", {h, l}, 2);
        cycle(20, 32, h, l, t);
        check(!h && l, "R5 low side during pwm low", {h, l}, 1);
    endtask

    task automatic t_zero;
        logic h, l, t;
        int rises;
        run(0, 1);
        rises = ls_rise_n;
        cycle(0, 0, h, l, t);
        check(!h && l, "R5 zero duty start of cycle", {h, l}, 1);
        cycle(0, 39, h, l, t);
        check(!h && l, "R5 zero duty end of cycle", {h, l}, 1);
        check(ls_rise_n == rises, "R5 zero duty low side never drops", ls_rise_n - rises, 0);
    endtask

    task automatic t_oc_windows;
        int s0;
        run(20, 1);
        s0 = strobe_n;
        oc_cycle(20, 1, BLANK);
        check(strobe_n == s0, "R7 fault inside blanking ignored", strobe_n - s0, 0);
        s0 = strobe_n;
        oc_cycle(20, BLANK + 1, 2 * BLANK - 1);
        check(strobe_n == s0, "R8 filter one sample short", strobe_n - s0, 0);
        s0 = strobe_n;
        oc_cycle(20, BLANK + 1, 2 * BLANK);
        check(strobe_n == s0 + 1, "R8 filter exactly met", strobe_n - s0, 1);
        s0 = strobe_n;
        oc_cycle(20, 1, 2 * BLANK);
        check(strobe_n == s0 + 1, "R7 fault spanning blanking", strobe_n - s0, 1);
    endtask

    task automatic t_oc_once;
        int s0;
        run(20, 1);
        s0 = strobe_n;
        oc_raw = 1'b1;
        run(P, 5);
        oc_raw = 1'b0;
        check(strobe_n == s0 + 5, "R9 one strobe per cycle at full duty", strobe_n - s0, 5);
        check(max_strobe_run == 1, "R8 strobe one clock wide", max_strobe_run, 1);
        run(20, 2);
    endtask

    task automatic t_refresh;
        logic h, l, t;
        int r0;
        run(20, 1);
        r0 = ls_rise_n;
        run(P, REFC);
        check(ls_rise_n == r0, "R6 no refresh before count", ls_rise_n - r0, 0);
        cycle(P, 10, h, l, t);
        check(!h && l, "R6 refresh low side forced", {h, l}, 1);
        check(ls_rise_n == r0 + 1, "R6 one refresh pulse", ls_rise_n - r0, 1);
        check(last_ls_len >= P / 2 - DEAD - 4 && last_ls_len <= P / 2 + 2,
              "R6 refresh about half cycle", last_ls_len, P / 2);
        run(P, REFC - 1);
        check(ls_rise_n == r0 + 1, "R6 count restarted", ls_rise_n - r0, 1);
        run(P, 1);
        check(ls_rise_n == r0 + 2, "R6 second refresh", ls_rise_n - r0, 2);
        run(20, 2);
    endtask

    task automatic t_disable;
        logic h, l, t;
        int s0;
        run(20, 1);
        @(negedge clk); drv_permit = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tristate == 1'b1, "R11 tristate after permit drop", tristate, 1);
        check(!hs && !ls, "R11 gates off after permit drop", {hs, ls}, 0);
        s0 = strobe_n;
        oc_raw = 1'b1;
        run(20, 2);
        oc_raw = 1'b0;
        check(strobe_n == s0, "R10 no strobe in tristate", strobe_n - s0, 0);
        drv_permit = 1'b1;
        cycle(20, 35, h, l, t);
        check(t == 1'b1, "R11 qualification restarted", t, 1);
        cycle(20, 35, h, l, t);
        check(t == 1'b0, "R11 rearmed after two pulses", t, 0);
        check(first_gate == 2, "R2 low side first after rearm", first_gate, 2);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prebias();
        t_follow();
        t_zero();
        t_oc_windows();
        t_oc_once();
        t_refresh();
        t_disable();
        run(20, 2);
        check(overlap_n == 0, "R3 gates never overlap", overlap_n, 0);
        check(min_gap >= DEAD && min_gap < 1000, "R4 dead time", min_gap, DEAD);
        finish_run();
    end

endmodule